// File: doc/BRIEF.md
# Privileged Interface Binding Lookup

This block carries out the binding step that turns a portable interface name into a logical unit number that the processor can route. It accepts a request word that carries an interface identifier and a device sequence number, a second data word, and the privilege level of the running code. It compares them in parallel against a small associative table and returns one result word. The low 12 bits of that word hold the logical unit number that was found. The upper bits carry data taken from the second operand.

Boot software loads the table through a configuration write port, one entry per write. Each entry stores a valid flag, an identifier, a device number, one required privilege level and a unit number. The privilege level takes part in the match, so the same identifier and device pair can bind to different units at different levels. A request that finds no entry is not an error: it returns unit number zero, and a later command can test for that value.

Top module: `ifc_bind_lookup`

## Requirements
- R1: The request word is split into a 12-bit device number in bits [11:0] and an identifier in bits [XLEN-1:12].
- R2: Result bits [XLEN-1:12] equal request operand B bits [XLEN-13:0], which is operand B modulo 2^(XLEN-12).
- R3: An entry matches only when it is valid and its identifier, device number and privilege all equal those of the request. A mismatch in any one of the three fields gives no match.
- R4: When no entry matches, result bits [11:0] are 0.
- R5: Privilege is one-hot: user 4'b0001, supervisor 4'b0010, hypervisor 4'b0100, machine 4'b1000. The same identifier and device pair can return different units at different privilege levels.
- R6: When several valid entries match, the entry with the lowest index supplies the unit.
- R7: The result appears with `rsp_vld` high exactly one cycle after `req_vld`. `rsp_vld` is low in every cycle that does not follow a request.
- R8: A table write takes effect for lookups that start on the following cycle, not for a lookup that starts in the same cycle. A write with `cfg_valid` low removes the entry at that index.
- R9: After reset `rsp_vld` is low and every table entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Index of the entry to write |
| cfg_valid | input | 1 | Valid flag written to the entry |
| cfg_ident | input | XLEN-12 | Identifier key of the entry |
| cfg_dev | input | 12 | Device number key of the entry |
| cfg_priv | input | 4 | Required one-hot privilege of the entry |
| cfg_unit | input | 12 | Unit number returned on a match |
| req_vld | input | 1 | Lookup request strobe |
| req_key | input | XLEN | Packed identifier and device number |
| req_data | input | XLEN | Operand B, source of the upper result bits |
| req_priv | input | 4 | Current one-hot privilege level |
| rsp_vld | output | 1 | Result valid strobe |
| rsp_word | output | XLEN | Unit number in [11:0], data in the upper bits |

## Verification
The bench builds the block with XLEN=32 and DEPTH=4. With only four entries, every table slot can be written, overwritten and invalidated. That makes it practical to sweep all four privilege levels over every programmed key, plus near-miss keys that differ in only one field. The small depth also makes it easy to load duplicate entries, which exercises lowest-index priority. The same-cycle write and lookup ordering is tested against the bench's own shadow table.

// File: rtl/ifc_bind_pkg.sv
package ifc_bind_pkg;
  localparam int unsigned UNIT_W = 12;
  localparam int unsigned PRIV_W = 4;
  localparam logic [PRIV_W-1:0] PRV_USER  = 4'b0001;
  localparam logic [PRIV_W-1:0] PRV_SUPER = 4'b0010;
  localparam logic [PRIV_W-1:0] PRV_HYPER = 4'b0100;
  localparam logic [PRIV_W-1:0] PRV_MACH  = 4'b1000;
endpackage

// File: rtl/ifc_bind_table.sv
module ifc_bind_table
  import ifc_bind_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic                      wr_valid,
  input  logic [XLEN-UNIT_W-1:0]    wr_ident,
  input  logic [UNIT_W-1:0]         wr_dev,
  input  logic [PRIV_W-1:0]         wr_priv,
  input  logic [UNIT_W-1:0]         wr_unit,
  input  logic [XLEN-UNIT_W-1:0]    look_ident,
  input  logic [UNIT_W-1:0]         look_dev,
  input  logic [PRIV_W-1:0]         look_priv,
  output logic [DEPTH-1:0]          hit_vec,
  output logic [DEPTH*UNIT_W-1:0]   unit_flat
);
  localparam int unsigned ID_W = XLEN - UNIT_W;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              load;
    logic              vld_q, vld_d;
    logic [ID_W-1:0]   id_q;
    logic [UNIT_W-1:0] dev_q;
    logic [PRIV_W-1:0] prv_q;
    logic [UNIT_W-1:0] unit_q;

    always_comb begin
      load  = wr_en && (wr_idx == IDX_W'(i));
      vld_d = load ? wr_valid : vld_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (load) begin
        id_q   <= wr_ident;
        dev_q  <= wr_dev;
        prv_q  <= wr_priv;
        unit_q <= wr_unit;
      end
    end

    always_comb begin
      hit_vec[i] = vld_q && (id_q == look_ident) && (dev_q == look_dev)
                   && (prv_q == look_priv);
      unit_flat[i*UNIT_W +: UNIT_W] = unit_q;
    end

    // R8: a write sets or clears the entry valid flag on the next cycle
    a_r8_write_valid : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i)) |=> (vld_q == $past(wr_valid)));
    // R3: no invalid entry can report a hit
    a_r3_invalid_no_hit : assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q |-> !hit_vec[i]);
  end
endmodule

// File: rtl/ifc_bind_prio.sv
module ifc_bind_prio
  import ifc_bind_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]        hit_vec,
  input  logic [DEPTH*UNIT_W-1:0] unit_flat,
  output logic                    any_hit,
  output logic [IDX_W-1:0]        sel_idx,
  output logic [UNIT_W-1:0]       sel_unit
);
  always_comb begin
    any_hit  = 1'b0;
    sel_idx  = '0;
    sel_unit = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (hit_vec[j]) begin
        any_hit  = 1'b1;
        sel_idx  = IDX_W'(j);
        sel_unit = unit_flat[j*UNIT_W +: UNIT_W];
      end
    end
  end

  // R6: the chosen entry hits and no lower-indexed entry does
  always_comb begin
    if (any_hit) begin
      a_r6_sel_hits : assert (hit_vec[sel_idx]);
      for (int k = 0; k < DEPTH; k++) begin
        if (k < int'(sel_idx)) a_r6_lowest_wins : assert (!hit_vec[k]);
      end
    end else begin
      a_r4_no_hit_zero : assert (hit_vec == '0);
    end
  end
endmodule

// File: rtl/ifc_bind_lookup.sv
module ifc_bind_lookup
  import ifc_bind_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic                    cfg_valid,
  input  logic [XLEN-UNIT_W-1:0]  cfg_ident,
  input  logic [UNIT_W-1:0]       cfg_dev,
  input  logic [PRIV_W-1:0]       cfg_priv,
  input  logic [UNIT_W-1:0]       cfg_unit,
  input  logic                    req_vld,
  input  logic [XLEN-1:0]         req_key,
  input  logic [XLEN-1:0]         req_data,
  input  logic [PRIV_W-1:0]       req_priv,
  output logic                    rsp_vld,
  output logic [XLEN-1:0]         rsp_word
);
  localparam int unsigned ID_W = XLEN - UNIT_W;

  logic [ID_W-1:0]         key_ident;
  logic [UNIT_W-1:0]       key_dev;
  logic [DEPTH-1:0]        hit_vec;
  logic [DEPTH*UNIT_W-1:0] unit_flat;
  logic                    any_hit;
  logic [IDX_W-1:0]        sel_idx;
  logic [UNIT_W-1:0]       sel_unit;
  logic                    vld_d, vld_q;
  logic [XLEN-1:0]         word_d, word_q;

  // R1: device number in the low bits, identifier above it
  always_comb begin
    key_dev   = req_key[UNIT_W-1:0];
    key_ident = req_key[XLEN-1:UNIT_W];
  end

  ifc_bind_table #(.XLEN(XLEN), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_idx    (cfg_idx),
    .wr_valid  (cfg_valid),
    .wr_ident  (cfg_ident),
    .wr_dev    (cfg_dev),
    .wr_priv   (cfg_priv),
    .wr_unit   (cfg_unit),
    .look_ident(key_ident),
    .look_dev  (key_dev),
    .look_priv (req_priv),
    .hit_vec   (hit_vec),
    .unit_flat (unit_flat)
  );

  ifc_bind_prio #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_prio (
    .hit_vec  (hit_vec),
    .unit_flat(unit_flat),
    .any_hit  (any_hit),
    .sel_idx  (sel_idx),
    .sel_unit (sel_unit)
  );

  always_comb begin
    vld_d  = req_vld;
    word_d = {req_data[ID_W-1:0], (any_hit ? sel_unit : {UNIT_W{1'b0}})};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (req_vld) word_q <= word_d;
  end

  assign rsp_vld  = vld_q;
  assign rsp_word = word_q;

  // R7: one response strobe per request, one cycle later
  a_r7_rsp_follows : assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  a_r7_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
  // R2: upper result bits carry operand B modulo 2^(XLEN-12)
  a_r2_data_pack : assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (rsp_word[XLEN-1:UNIT_W] == $past(req_data[ID_W-1:0])));
  // R4: a miss returns unit zero
  a_r4_miss_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && hit_vec == '0) |=> (rsp_word[UNIT_W-1:0] == '0));
endmodule

// File: tb/sim_ifc_bind_lookup.sv
module sim_ifc_bind_lookup;
  localparam int XLEN = 32;
  localparam int DEPTH = 4;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic cfg_valid = 1'b0;
  logic [19:0] cfg_ident = '0;
  logic [11:0] cfg_dev = '0;
  logic [3:0] cfg_priv = '0;
  logic [11:0] cfg_unit = '0;
  logic req_vld = 1'b0;
  logic [31:0] req_key = '0;
  logic [31:0] req_data = '0;
  logic [3:0] req_priv = '0;
  logic rsp_vld;
  logic [31:0] rsp_word;

  int n_chk = 0;
  int n_bad = 0;

  bit         m_v[DEPTH];
  logic [19:0] m_id[DEPTH];
  logic [11:0] m_dev[DEPTH];
  logic [3:0]  m_pr[DEPTH];
  logic [11:0] m_un[DEPTH];

  always #2.5 clk = ~clk;

  ifc_bind_lookup #(.XLEN(XLEN), .DEPTH(DEPTH), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_ident(cfg_ident), .cfg_dev(cfg_dev),
    .cfg_priv(cfg_priv), .cfg_unit(cfg_unit), .req_vld(req_vld),
    .req_key(req_key), .req_data(req_data), .req_priv(req_priv),
    .rsp_vld(rsp_vld), .rsp_word(rsp_word));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] model(input logic [19:0] id, input logic [11:0] dv,
                                        input logic [3:0] pr);
    for (int i = DEPTH - 1; i >= 0; i--) ;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_id[i] == id && m_dev[i] == dv && m_pr[i] == pr) return m_un[i];
    return 12'd0;
  endfunction

  task automatic wr(input int idx, input bit v, input logic [19:0] id,
                    input logic [11:0] dv, input logic [3:0] pr, input logic [11:0] un);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_valid = v;
    cfg_ident = id; cfg_dev = dv; cfg_priv = pr; cfg_unit = un;
    @(negedge clk);
    cfg_we = 1'b0;
    m_v[idx] = v; m_id[idx] = id; m_dev[idx] = dv; m_pr[idx] = pr; m_un[idx] = un;
  endtask

  task automatic look(input string tag, input logic [19:0] id, input logic [11:0] dv,
                      input logic [3:0] pr, input logic [31:0] d);
    logic [31:0] exp;
    exp = {d[19:0], model(id, dv, pr)};
    @(negedge clk);
    req_vld = 1'b1; req_key = {id, dv}; req_data = d; req_priv = pr;
    @(negedge clk);
    req_vld = 1'b0;
    check({tag, " R7 strobe"}, {31'd0, rsp_vld}, 32'd1);
    check(tag, rsp_word, exp);
    @(negedge clk);
    check("R7 strobe drops", {31'd0, rsp_vld}, 32'd0);
  endtask

  initial begin
    #20000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [19:0] ids[3];
    logic [11:0] devs[3];
    logic [3:0]  prs[4];
    int k;
    ids[0] = 20'hABCDE; ids[1] = 20'h12345; ids[2] = 20'hABCDF;
    devs[0] = 12'd0; devs[1] = 12'd1; devs[2] = 12'd5;
    prs[0] = 4'b0001; prs[1] = 4'b0010; prs[2] = 4'b0100; prs[3] = 4'b1000;
    for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 rsp_vld in reset", {31'd0, rsp_vld}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 rsp_vld after reset", {31'd0, rsp_vld}, 32'd0);
    look("R9 empty table misses", 20'hABCDE, 12'd0, 4'b0001, 32'hFFFF_FFFF);

    // R5: same key, different unit per privilege
    wr(0, 1, 20'hABCDE, 12'd0, 4'b0001, 12'd32);
    wr(1, 1, 20'hABCDE, 12'd0, 4'b0010, 12'd34);
    wr(2, 1, 20'hABCDE, 12'd0, 4'b0100, 12'd34);
    wr(3, 1, 20'h12345, 12'd5, 4'b1000, 12'd7);
    look("R5 user unit", 20'hABCDE, 12'd0, 4'b0001, 32'h0000_1000);
    look("R5 super unit", 20'hABCDE, 12'd0, 4'b0010, 32'h0000_2000);
    look("R4 machine miss", 20'hABCDE, 12'd0, 4'b1000, 32'h0000_3000);

    // R1 R2 R3 R4: sweep keys x privileges x data patterns
    k = 0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int p = 0; p < 4; p++) begin
          look("R3 sweep", ids[a], devs[b], prs[p], 32'hA5A5_0F0F ^ (k * 32'h0123_4567));
          k++;
        end

    // R6: duplicate key, lowest index wins
    wr(3, 1, 20'hABCDE, 12'd0, 4'b0001, 12'd99);
    look("R6 lowest index", 20'hABCDE, 12'd0, 4'b0001, 32'h1234_5678);
    check("R6 unit 32", {20'd0, rsp_word[11:0]}, 32'd32);
    // R8: invalidation exposes the next entry
    wr(0, 0, 20'hABCDE, 12'd0, 4'b0001, 12'd32);
    look("R8 invalidated", 20'hABCDE, 12'd0, 4'b0001, 32'h8765_4321);
    check("R8 unit 99", {20'd0, rsp_word[11:0]}, 32'd99);

    // R8: same-cycle write is not seen, next-cycle lookup sees it
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_valid = 1'b1; cfg_ident = 20'h0F00D;
    cfg_dev = 12'd3; cfg_priv = 4'b0100; cfg_unit = 12'd77;
    req_vld = 1'b1; req_key = {20'h0F00D, 12'd3}; req_priv = 4'b0100; req_data = 32'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R8 same-cycle old table", rsp_word, 32'h0000_0000);
    req_data = 32'h000F_FFFF;
    @(negedge clk);
    req_vld = 1'b0;
    check("R8 next-cycle new entry", rsp_word, {20'hFFFFF, 12'd77});
    m_v[0] = 1; m_id[0] = 20'h0F00D; m_dev[0] = 12'd3; m_pr[0] = 4'b0100; m_un[0] = 12'd77;
    look("R3 priv mismatch", 20'h0F00D, 12'd3, 4'b1000, 32'h1);

    // R9: reset clears the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 rsp_vld reset", {31'd0, rsp_vld}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
    look("R9 cleared table", 20'h0F00D, 12'd3, 4'b0100, 32'h2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule